// File: doc/BRIEF.md
# Power-Management Event Block with Free-Running Timer

This block holds a fixed set of power-management registers beside a free-running timer. The timer advances once for each pulse of a tick-enable input, which is intended to be driven at 3.579545 MHz. An event status word records timer overflow, power-button presses and wake-up. Software clears status bits by writing ones to them. An enable word selects which status bits may raise the system control interrupt (SCI). A control word carries the SCI-enable flag and a sleep request. When software sets the sleep request, the block emits a one-cycle power-off request, or emits a reset request together with a resume flag.

Software reaches the registers through a simple word/dword port. A read returns its data one cycle after the request. A separate byte port models the APM command and status bytes. Two command values on that port turn the SCI-enable flag on and off.

Overflow detection works as follows. An internal overflow point is always aligned to a step of 2^OVF_SHIFT counts. The default OVF_SHIFT is 23, so status is raised each time bit 23 of the count toggles. When software clears a timer status bit that is currently set, the block moves the overflow point to the next aligned step above the present count.

Top module: `pm_event_timer`

## Requirements
- R1: The timer count starts at zero after reset and rises by one on each clock with `tick_en` high, holding otherwise. A read of offset 0x08 returns the low 24 bits of the count, zero-extended to 32 bits.
- R2: Status bit 0 (timer) reads as one whenever the count is at or above the overflow point. A status read reports the comparison made in the same cycle as the read. Because the point resets to zero, bit 0 reads as one straight after reset.
- R3: Writing a one to status bit 0 while it is set moves the overflow point to (count + 2^OVF_SHIFT) rounded down to a multiple of 2^OVF_SHIFT. Writing a one to bit 0 while it is clear leaves the point where it was.
- R4: A write to the status word (offset 0x00) clears each bit written as one and leaves bits written as zero unchanged.
- R5: The enable word (offset 0x02) reads back the last 16-bit value written to it.
- R6: `sci` is high one cycle after (status AND enable AND 0x0521) is nonzero. The mask 0x0521 selects bit 0 (timer), bit 5 (global), bit 8 (power button) and bit 10 (RTC). Other status bits, such as bit 15, never raise `sci`.
- R7: A write to the control word (offset 0x04) stores the value with bit 13 (sleep request) forced to zero.
- R8: A control write with bit 13 set decodes a sleep type from bits 12:10. Type 0 gives a one-cycle `shutdown_req`. Type 1 sets status bits 15 and 8 and gives one-cycle `reset_req` and `resume_flag`. Any other type does nothing. A control write with bit 13 clear gives no pulse.
- R9: On the APM port, a write of 0xF1 to the command byte (`apm_sel`=0) sets control bit 0, a write of 0xF0 clears it, and any other value leaves it unchanged. The command byte and the status byte (`apm_sel`=1) both read back the last value written.
- R10: A `pwrbtn_evt` pulse sets status bit 8 only while enable bit 8 is one.
- R11: Reads of any offset other than 0x00, 0x02, 0x04 and 0x08 return zero.
- R12: Reset clears the status, enable and control words, both APM bytes and all request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advance enable (3.579545 MHz rate) |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| apm_wr | input | 1 | APM byte write strobe |
| apm_rd | input | 1 | APM byte read strobe |
| apm_sel | input | 1 | 0 = command byte, 1 = status byte |
| apm_wdata | input | 8 | APM byte write data |
| apm_rdata | output | 8 | APM byte read data, valid the cycle after `apm_rd` |
| sci | output | 1 | System control interrupt, level |
| shutdown_req | output | 1 | Power-off request pulse |
| reset_req | output | 1 | Reset request pulse |
| resume_flag | output | 1 | Suspend-resume flag pulse |

## Verification
A wrong overflow point would show up as timer status appearing at the wrong count. The bench catches this on the next status read, within one step of ticks, because its model re-derives the point on every clear. A stuck or wrongly merged status bit would surface at once as a miscompare on the next status read. The same fault would also appear as a wrong `sci` level one cycle after the state settles. A slip in the sleep decode would show as a missing or extra request pulse in the cycle that follows the control write.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_AW = 6;

  localparam logic [PM_AW-1:0] OFS_STS = 6'h00;
  localparam logic [PM_AW-1:0] OFS_EN  = 6'h02;
  localparam logic [PM_AW-1:0] OFS_CTL = 6'h04;
  localparam logic [PM_AW-1:0] OFS_TMR = 6'h08;

  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;
  localparam logic [15:0] SUSPEND_SET  = 16'h8100;
  localparam int          BIT_PWR      = 8;
  localparam int          BIT_SLP_REQ  = 13;

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;

  typedef enum logic [2:0] {
    SLP_POWER_OFF = 3'd0,
    SLP_SUSPEND   = 3'd1
  } slp_kind_e;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int CNT_W     = 32,
  parameter int RD_W      = 24,
  parameter int OVF_SHIFT = 23
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            rearm,
  output logic [RD_W-1:0] rd_cnt,
  output logic            ovf_hit
);
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(1) << OVF_SHIFT;
  localparam logic [CNT_W-1:0] ALN_MASK = ~(STEP - CNT_W'(1));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] point_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      point_q <= '0;
    end else begin
      if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
      if (rearm)   point_q <= (cnt_q + STEP) & ALN_MASK;
    end
  end

  assign ovf_hit = (cnt_q >= point_q);
  assign rd_cnt  = cnt_q[RD_W-1:0];

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));
  p_rearm_ahead_r3: assert property (@(posedge clk) disable iff (rst)
    (rearm && !tick_en) |=> !ovf_hit);
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PM_AW-1:0] addr,
  input  logic [15:0]      wdata,
  input  logic             ovf_hit,
  input  logic             pwrbtn_evt,
  input  logic             apm_wr,
  input  logic             apm_sel,
  input  logic [7:0]       apm_wdata,
  output logic [15:0]      sts_vis,
  output logic [15:0]      en_q,
  output logic [15:0]      ctl_q,
  output logic [7:0]       apm_cmd_q,
  output logic [7:0]       apm_sts_q,
  output logic             rearm,
  output logic             shutdown_req,
  output logic             reset_req,
  output logic             resume_flag
);
  logic [15:0] sts_q;
  logic [15:0] sts_n;
  logic [15:0] ctl_n;
  logic        wr_sts;
  logic        wr_ctl;
  logic        slp_go;
  logic [2:0]  slp_kind;

  assign sts_vis  = sts_q | {15'b0, ovf_hit};
  assign wr_sts   = wr_en && (addr == OFS_STS);
  assign wr_ctl   = wr_en && (addr == OFS_CTL);
  assign slp_go   = wr_ctl && wdata[BIT_SLP_REQ];
  assign slp_kind = wdata[12:10];
  assign rearm    = wr_sts && sts_vis[0] && wdata[0];

  always_comb begin
    sts_n = sts_vis;
    if (wr_sts) sts_n = sts_n & ~wdata;
    if (pwrbtn_evt && en_q[BIT_PWR]) sts_n[BIT_PWR] = 1'b1;
    if (slp_go && slp_kind == SLP_SUSPEND) sts_n = sts_n | SUSPEND_SET;
  end

  always_comb begin
    ctl_n = ctl_q;
    if (wr_ctl) begin
      ctl_n = wdata;
      ctl_n[BIT_SLP_REQ] = 1'b0;
    end
    if (apm_wr && !apm_sel) begin
      if (apm_wdata == APM_SCI_ON)       ctl_n[0] = 1'b1;
      else if (apm_wdata == APM_SCI_OFF) ctl_n[0] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q        <= '0;
      en_q         <= '0;
      ctl_q        <= '0;
      apm_cmd_q    <= '0;
      apm_sts_q    <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      resume_flag  <= 1'b0;
    end else begin
      sts_q <= sts_n;
      ctl_q <= ctl_n;
      if (wr_en && addr == OFS_EN) en_q <= wdata;
      if (apm_wr) begin
        if (apm_sel) apm_sts_q <= apm_wdata;
        else         apm_cmd_q <= apm_wdata;
      end
      shutdown_req <= slp_go && (slp_kind == SLP_POWER_OFF);
      reset_req    <= slp_go && (slp_kind == SLP_SUSPEND);
      resume_flag  <= slp_go && (slp_kind == SLP_SUSPEND);
    end
  end

  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && !pwrbtn_evt) |=> (sts_q & $past(wdata)) == 16'h0);
  p_ctl_no_slp_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> !ctl_q[BIT_SLP_REQ]);
  p_slp_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_req && reset_req));
  p_apm_on_r9: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && !apm_sel && apm_wdata == APM_SCI_ON) |=> ctl_q[0]);
  p_pwr_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!sts_q[BIT_PWR] && !en_q[BIT_PWR] && !slp_go) |=> !sts_q[BIT_PWR]);
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
  import pm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RD_W      = 24,
  parameter int OVF_SHIFT = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             pwrbtn_evt,
  input  logic [PM_AW-1:0] reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             apm_wr,
  input  logic             apm_rd,
  input  logic             apm_sel,
  input  logic [7:0]       apm_wdata,
  output logic [7:0]       apm_rdata,
  output logic             sci,
  output logic             shutdown_req,
  output logic             reset_req,
  output logic             resume_flag
);
  logic [RD_W-1:0] rd_cnt;
  logic            ovf_hit;
  logic            rearm;
  logic [15:0]     sts_vis;
  logic [15:0]     en_q;
  logic [15:0]     ctl_q;
  logic [7:0]      apm_cmd_q;
  logic [7:0]      apm_sts_q;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[31:16];

  pm_timer #(
    .CNT_W(CNT_W), .RD_W(RD_W), .OVF_SHIFT(OVF_SHIFT)
  ) timer_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rearm(rearm),
    .rd_cnt(rd_cnt), .ovf_hit(ovf_hit)
  );

  pm_evt_regs regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[15:0]), .ovf_hit(ovf_hit), .pwrbtn_evt(pwrbtn_evt),
    .apm_wr(apm_wr), .apm_sel(apm_sel), .apm_wdata(apm_wdata),
    .sts_vis(sts_vis), .en_q(en_q), .ctl_q(ctl_q),
    .apm_cmd_q(apm_cmd_q), .apm_sts_q(apm_sts_q), .rearm(rearm),
    .shutdown_req(shutdown_req), .reset_req(reset_req),
    .resume_flag(resume_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      apm_rdata <= '0;
      sci       <= 1'b0;
    end else begin
      sci <= |(sts_vis & en_q & SCI_SRC_MASK);
      if (reg_rd) begin
        case (reg_addr)
          OFS_STS: reg_rdata <= {16'h0, sts_vis};
          OFS_EN:  reg_rdata <= {16'h0, en_q};
          OFS_CTL: reg_rdata <= {16'h0, ctl_q};
          OFS_TMR: reg_rdata <= 32'(rd_cnt);
          default: reg_rdata <= '0;
        endcase
      end
      if (apm_rd) apm_rdata <= apm_sel ? apm_sts_q : apm_cmd_q;
    end
  end

  p_sci_gate_r6: assert property (@(posedge clk) disable iff (rst)
    ((en_q & SCI_SRC_MASK) == 16'h0) |=> !sci);
  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != OFS_STS && reg_addr != OFS_EN &&
     reg_addr != OFS_CTL && reg_addr != OFS_TMR) |=> reg_rdata == 32'h0);
endmodule

// File: tb/pm_event_timer_tb_top.sv
module pm_event_timer_tb_top;
  localparam int SHIFT = 6;
  localparam int unsigned STEP = 1 << SHIFT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        pwrbtn_evt = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        apm_wr = 1'b0;
  logic        apm_rd = 1'b0;
  logic        apm_sel = 1'b0;
  logic [7:0]  apm_wdata = '0;
  logic [7:0]  apm_rdata;
  logic        sci, shutdown_req, reset_req, resume_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int unsigned m_cnt, m_pt;
  logic [15:0] m_sts, m_en, m_ctl;

  always #4 clk = ~clk;

  pm_event_timer #(.CNT_W(32), .RD_W(24), .OVF_SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .apm_wr(apm_wr), .apm_rd(apm_rd), .apm_sel(apm_sel),
    .apm_wdata(apm_wdata), .apm_rdata(apm_rdata), .sci(sci),
    .shutdown_req(shutdown_req), .reset_req(reset_req),
    .resume_flag(resume_flag)
  );

  function automatic logic [15:0] vis_sts();
    return m_sts | {15'b0, (m_cnt >= m_pt)};
  endfunction

  function automatic logic exp_sci();
    return |(vis_sts() & m_en & 16'h0521);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      m_cnt++;
    end
    tick_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    logic [15:0] v;
    reg_addr = a; reg_wdata = {16'h0, d}; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      6'h00: begin
        v = vis_sts();
        if (v[0] && d[0]) m_pt = (m_cnt + STEP) & ~(STEP - 1);
        m_sts = v & ~d;
      end
      6'h02: m_en = d;
      6'h04: begin
        m_ctl = d & 16'hDFFF;
        if (d[13] && d[12:10] == 3'd1) m_sts = m_sts | 16'h8100;
      end
      default: ;
    endcase
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic rd_sts(string tag);
    rd(6'h00, {16'h0, vis_sts()}, tag);
  endtask

  task automatic apm_write(logic s, logic [7:0] d);
    apm_sel = s; apm_wdata = d; apm_wr = 1'b1;
    @(negedge clk);
    apm_wr = 1'b0;
    if (!s && d == 8'hF1) m_ctl[0] = 1'b1;
    if (!s && d == 8'hF0) m_ctl[0] = 1'b0;
  endtask

  task automatic apm_read(logic s, logic [7:0] exp, string tag);
    apm_sel = s; apm_rd = 1'b1;
    @(negedge clk);
    apm_rd = 1'b0;
    chk(tag, {24'h0, apm_rdata}, {24'h0, exp});
  endtask

  task automatic press();
    pwrbtn_evt = 1'b1;
    @(negedge clk);
    pwrbtn_evt = 1'b0;
    if (m_en[8]) m_sts[8] = 1'b1;
  endtask

  task automatic sleep_wr(logic [15:0] d, logic e_sd, logic e_rs, string tag);
    wr(6'h04, d);
    chk({tag, " shutdown pulse"}, {31'h0, shutdown_req}, {31'h0, e_sd});
    chk({tag, " reset pulse"}, {31'h0, reset_req}, {31'h0, e_rs});
    chk({tag, " resume pulse"}, {31'h0, resume_flag}, {31'h0, e_rs});
    @(negedge clk);
    chk({tag, " pulse ends"}, {29'h0, shutdown_req, reset_req, resume_flag}, 32'h0);
    rd(6'h04, {16'h0, m_ctl}, {tag, " ctl readback R7"});
  endtask

  task automatic sci_chk(string tag);
    @(negedge clk);
    chk(tag, {31'h0, sci}, {31'h0, exp_sci()});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int op;
    m_cnt = 0; m_pt = 0; m_sts = '0; m_en = '0; m_ctl = '0;
    seed = 32'd1234;
    void'($urandom(seed));
    idle(3);
    rst = 1'b0;
    chk("R12 sci after reset", {31'h0, sci}, 32'h0);
    chk("R12 pulses after reset", {29'h0, shutdown_req, reset_req, resume_flag}, 32'h0);
    rd(6'h02, 32'h0, "R12 enable reset");
    rd(6'h04, 32'h0, "R12 control reset");
    rd(6'h08, 32'h0, "R1 timer reset");
    rd(6'h00, 32'h1, "R2 timer status set right after reset");
    apm_read(1'b0, 8'h00, "R12 apm cmd reset");
    apm_read(1'b1, 8'h00, "R12 apm sts reset");

    ticks(10);
    rd(6'h08, 32'd10, "R1 timer after 10 ticks");
    idle(5);
    rd(6'h08, 32'd10, "R1 timer holds without tick");

    wr(6'h00, 16'h0001);
    chk("R3 point after clear", m_pt, 32'd64);
    rd_sts("R3 status cleared");
    ticks(53);
    rd_sts("R2 status below point (count 63)");
    ticks(1);
    rd(6'h00, 32'h1, "R2 status at point (count 64)");
    wr(6'h00, 16'h0001);
    wr(6'h00, 16'h0001);
    chk("R3 point unchanged when clear", m_pt, 32'd128);
    ticks(63);
    rd(6'h00, 32'h0, "R3 status below re-armed point");
    ticks(1);
    rd(6'h00, 32'h1, "R2 status at re-armed point");

    wr(6'h02, 16'h0001);
    rd(6'h02, 32'h0001, "R5 enable readback");
    sci_chk("R6 sci on timer status");

    sleep_wr(16'h2401, 1'b0, 1'b1, "R8 suspend type");
    rd(6'h00, 32'h8101, "R8 suspend sets status 15 and 8");
    wr(6'h02, 16'h8000);
    sci_chk("R6 bit 15 outside mask");
    chk("R6 sci low with bit 15 only", {31'h0, sci}, 32'h0);
    sleep_wr(16'h2000, 1'b1, 1'b0, "R8 power-off type");
    sleep_wr(16'h3C00, 1'b0, 1'b0, "R8 other type");
    sleep_wr(16'h0400, 1'b0, 1'b0, "R8 no request bit");

    wr(6'h00, 16'h8000);
    rd(6'h00, 32'h0101, "R4 only written ones cleared");
    wr(6'h00, 16'h0100);
    wr(6'h02, 16'h0000);
    press();
    rd(6'h00, 32'h0001, "R10 press ignored when disabled");
    wr(6'h02, 16'h0100);
    press();
    rd(6'h00, 32'h0101, "R10 press sets bit 8");
    sci_chk("R6 sci on power button");

    apm_write(1'b0, 8'hF1);
    rd(6'h04, {16'h0, m_ctl}, "R9 F1 sets sci enable");
    chk("R9 ctl bit0 after F1", {31'h0, m_ctl[0]}, 32'h1);
    apm_write(1'b0, 8'h55);
    rd(6'h04, {16'h0, m_ctl}, "R9 other cmd no effect");
    apm_write(1'b0, 8'hF0);
    rd(6'h04, {16'h0, m_ctl}, "R9 F0 clears sci enable");
    apm_write(1'b1, 8'hA5);
    apm_read(1'b1, 8'hA5, "R9 apm status byte");
    apm_read(1'b0, 8'hF0, "R9 apm command byte");

    rd(6'h06, 32'h0, "R11 offset 0x06");
    rd(6'h0A, 32'h0, "R11 offset 0x0A");
    rd(6'h3E, 32'h0, "R11 offset 0x3E");

    for (int it = 0; it < 400; it++) begin
      op = int'($urandom_range(0, 6));
      case (op)
        0: ticks(int'($urandom_range(0, 40)));
        1: wr(6'h00, 16'($urandom()));
        2: wr(6'h02, 16'($urandom()));
        3: press();
        4: rd(6'h08, m_cnt & 32'hFFFFFF, "R1 random timer read");
        5: rd_sts("R2 R4 random status read");
        default: sci_chk("R6 random sci level");
      endcase
    end
    rd(6'h02, {16'h0, m_en}, "R5 final enable");
    rd_sts("R3 final status");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule